// File: doc/BRIEF.md
# Telemetry Frame Synchronizer

This block finds and then follows frame boundaries in a serial NRZ-L telemetry stream. Bits arrive one per cycle in which `bit_en` is high, taken from one of three sources: recovered data, external data, or a built-in test generator that repeats a frame ending in the programmed sync word. A shift window of the last `PAT_W` bits is compared against the sync word. Only the bit positions selected by a mask are compared, and the number of mismatching positions is tested against a limit that depends on the current state.

The tracker has three states. SEARCH hunts bit by bit for the word. CHECK confirms a candidate over a programmable number of frames. LOCK keeps going through a programmable number of consecutive bad frames before it gives up. Two options can be enabled. With automatic polarity, an inverted sync word is accepted and the data output is flipped to correct it. With slip tolerance, a word that turns up one bit early or one bit late is accepted in CHECK and LOCK and the frame counter realigns to it. Configuration uses a small write-only register port.

Top module: `tlm_frame_sync`

## Requirements
- R1: After a synchronous reset, `sync_state` is 0 (SEARCH), `frame_start` is 0, `frame_pos` is 0 and `data_out` is 0.
- R2: The error count is popcount((window XOR pattern) AND mask). The newest bit sits at window bit 0, so the pattern is sent MSB first. Positions whose mask bit is 0 never count. Registers: 0 pattern, 1 mask, 2 frame length, 3 limits (search [7:0], check [15:8], lock [23:16]), 4 frame counts (good-to-lock [7:0], bad-to-search [15:8]), 5 control (bit 0 auto-polarity, bit 1 slip, bits [3:2] source).
- R3: In SEARCH, a window whose error count is at or below the search limit moves the state to 1 (CHECK), raises `frame_start` and sets `frame_pos` to 0 for that bit. Any other window leaves the state in SEARCH.
- R4: In CHECK, the window at the expected position counts as good when its errors are at or below the check limit. The state moves to 2 (LOCK) once the number of good frames reaches the good-to-lock count. One bad frame in CHECK returns the state to SEARCH.
- R5: In LOCK, the lock limit applies. A good frame clears the miss count. A bad frame gives no `frame_start`, the counter keeps running, and the state returns to SEARCH when the consecutive bad frames reach the bad-to-search count.
- R6: `frame_pos` is 0 on the last bit of a recognised sync word, counts up by one per bit, wraps from length−1 to 0, and stays at 0 while in SEARCH.
- R7: `frame_start` is high for exactly one bit period, only on the last bit of an accepted sync word, and never in SEARCH.
- R8: With auto-polarity on, SEARCH also accepts the inverted pattern. From then on the inverted pattern is the reference and `data_out` is the inverse of the input. With auto-polarity off, an inverted word is not accepted.
- R9: `data_out` is the selected input bit, XORed with the polarity flag, registered on each `bit_en`.
- R10: With slip on, CHECK and LOCK accept the sync word one bit before or one bit after the expected position, with `frame_start` and `frame_pos` = 0 at that bit. With slip off, an off-position word is not recognised.
- R11: Source 0 selects `rec_bit` and source 1 selects `ext_bit`. Sources 2 and 3 select the test generator, which emits `len`-bit frames whose last `PAT_W` bits are the pattern MSB first and whose other bits are 0.
- R12: No output changes in a cycle without `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| bit_en | input | 1 | One cycle per received bit |
| rec_bit | input | 1 | Recovered data bit |
| ext_bit | input | 1 | External data bit |
| sync_state | output | 2 | 0 SEARCH, 1 CHECK, 2 LOCK |
| frame_start | output | 1 | Sync word accepted on this bit |
| frame_pos | output | LEN_W | Bit position within the frame |
| data_out | output | 1 | Polarity-corrected data |

## Verification
The bench builds the block with `PAT_W` = 16 and `LEN_W` = 8 and programs 40-bit frames, so each frame takes only 80 clocks. This keeps several acquisitions, loss-of-lock sequences and slipped frames inside a short run. At 16 bits, error counts of one to three and masked-off low bits are easy to place by hand, and frames of 39 and 41 bits exercise the early and late slip windows.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOCK   = 2'd2
  } fsync_state_e;

  localparam int REG_PAT   = 0;
  localparam int REG_MASK  = 1;
  localparam int REG_LEN   = 2;
  localparam int REG_LIMIT = 3;
  localparam int REG_COUNT = 4;
  localparam int REG_CTRL  = 5;

  localparam logic [1:0] SRC_RECOV = 2'd0;
  localparam logic [1:0] SRC_EXT   = 2'd1;
endpackage

// File: rtl/fsync_regs.sv
module fsync_regs #(
  parameter int PAT_W   = 32,
  parameter int LEN_W   = 16,
  parameter int LIM_W   = 6,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int DEF_LEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [PAT_W-1:0]  pat,
  output logic [PAT_W-1:0]  mask,
  output logic [LEN_W-1:0]  len,
  output logic [LIM_W-1:0]  lim_search,
  output logic [LIM_W-1:0]  lim_check,
  output logic [LIM_W-1:0]  lim_lock,
  output logic [CNT_W-1:0]  need_good,
  output logic [CNT_W-1:0]  need_bad,
  output logic              auto_pol,
  output logic              slip_en,
  output logic [1:0]        src_sel
);
  import fsync_pkg::*;

  logic wdata_unused;
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat        <= '0;
      mask       <= '1;
      len        <= LEN_W'(DEF_LEN);
      lim_search <= '0;
      lim_check  <= '0;
      lim_lock   <= '0;
      need_good  <= CNT_W'(1);
      need_bad   <= CNT_W'(1);
      auto_pol   <= 1'b0;
      slip_en    <= 1'b0;
      src_sel    <= SRC_RECOV;
    end else if (we) begin
      case (addr)
        ADDR_W'(REG_PAT):   pat  <= wdata[PAT_W-1:0];
        ADDR_W'(REG_MASK):  mask <= wdata[PAT_W-1:0];
        ADDR_W'(REG_LEN):   len  <= wdata[LEN_W-1:0];
        ADDR_W'(REG_LIMIT): begin
          lim_search <= wdata[LIM_W-1:0];
          lim_check  <= wdata[8+LIM_W-1:8];
          lim_lock   <= wdata[16+LIM_W-1:16];
        end
        ADDR_W'(REG_COUNT): begin
          need_good <= wdata[CNT_W-1:0];
          need_bad  <= wdata[8+CNT_W-1:8];
        end
        ADDR_W'(REG_CTRL): begin
          auto_pol <= wdata[0];
          slip_en  <= wdata[1];
          src_sel  <= wdata[3:2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsync_source.sv
module fsync_source #(
  parameter int PAT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [1:0]       src_sel,
  input  logic             rec_bit,
  input  logic             ext_bit,
  input  logic [PAT_W-1:0] pat,
  input  logic [LEN_W-1:0] len,
  output logic             bit_o
);
  import fsync_pkg::*;

  localparam int PIDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

  logic [LEN_W-1:0]  gen_pos;
  logic [LEN_W-1:0]  gen_dist;
  logic [PIDX_W-1:0] gen_idx;
  logic              gen_bit;
  logic              gen_sel;

  assign gen_sel  = (src_sel != SRC_RECOV) && (src_sel != SRC_EXT);
  assign gen_dist = len - LEN_W'(1) - gen_pos;
  assign gen_idx  = gen_dist[PIDX_W-1:0];
  assign gen_bit  = (gen_dist < LEN_W'(PAT_W)) ? pat[gen_idx] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_pos <= '0;
    end else if (bit_en && gen_sel) begin
      gen_pos <= (gen_pos >= len - LEN_W'(1)) ? '0 : gen_pos + LEN_W'(1);
    end
  end

  always_comb begin
    case (src_sel)
      SRC_RECOV: bit_o = rec_bit;
      SRC_EXT:   bit_o = ext_bit;
      default:   bit_o = gen_bit;
    endcase
  end
endmodule

// File: rtl/fsync_corr.sv
module fsync_corr #(
  parameter int PAT_W = 32,
  parameter int LIM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             din,
  input  logic [PAT_W-1:0] pat,
  input  logic [PAT_W-1:0] mask,
  output logic [LIM_W-1:0] err_true,
  output logic [LIM_W-1:0] err_inv
);
  logic [PAT_W-1:0] win;
  logic [PAT_W-1:0] nwin;

  function automatic logic [LIM_W-1:0] popcnt(input logic [PAT_W-1:0] v);
    logic [LIM_W-1:0] s;
    s = '0;
    for (int i = 0; i < PAT_W; i++) s = s + LIM_W'(v[i]);
    return s;
  endfunction

  assign nwin     = {win[PAT_W-2:0], din};
  assign err_true = popcnt((nwin ^ pat) & mask);
  assign err_inv  = popcnt((nwin ^ ~pat) & mask);

  always_ff @(posedge clk) begin
    if (rst)         win <= '0;
    else if (bit_en) win <= nwin;
  end
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl #(
  parameter int LEN_W = 16,
  parameter int LIM_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             din,
  input  logic [LIM_W-1:0] err_true,
  input  logic [LIM_W-1:0] err_inv,
  input  logic [LEN_W-1:0] len,
  input  logic [LIM_W-1:0] lim_search,
  input  logic [LIM_W-1:0] lim_check,
  input  logic [LIM_W-1:0] lim_lock,
  input  logic [CNT_W-1:0] need_good,
  input  logic [CNT_W-1:0] need_bad,
  input  logic             auto_pol,
  input  logic             slip_en,
  output fsync_pkg::fsync_state_e state,
  output logic             fs,
  output logic [LEN_W-1:0] pos,
  output logic             dout
);
  import fsync_pkg::*;

  fsync_state_e     st_n;
  logic [LEN_W-1:0] pos_n;
  logic             fs_n, inv, inv_n, pend, pend_n;
  logic [CNT_W-1:0] good, good_n, miss, miss_n;
  logic [CNT_W:0]   good_inc, miss_inc;
  logic [LIM_W-1:0] lim;
  logic             ok_t, ok_i, ok_cur, f_good, f_bad;
  logic             at_exp, at_early;

  assign lim      = (state == ST_SEARCH) ? lim_search :
                    (state == ST_CHECK)  ? lim_check  : lim_lock;
  assign ok_t     = err_true <= lim;
  assign ok_i     = err_inv  <= lim;
  assign ok_cur   = inv ? ok_i : ok_t;
  assign at_exp   = pos == len - LEN_W'(1);
  assign at_early = pos == len - LEN_W'(2);
  assign good_inc = {1'b0, good} + (CNT_W+1)'(1);
  assign miss_inc = {1'b0, miss} + (CNT_W+1)'(1);

  always_comb begin
    st_n   = state;
    pos_n  = at_exp ? '0 : pos + LEN_W'(1);
    fs_n   = 1'b0;
    inv_n  = inv;
    good_n = good;
    miss_n = miss;
    pend_n = 1'b0;
    f_good = 1'b0;
    f_bad  = 1'b0;
    if (state == ST_SEARCH) begin
      pos_n = '0;
      if (ok_t || (auto_pol && ok_i)) begin
        st_n   = ST_CHECK;
        fs_n   = 1'b1;
        inv_n  = !ok_t;
        good_n = '0;
      end
    end else begin
      if (slip_en && at_early && ok_cur) begin
        f_good = 1'b1;
        pos_n  = '0;
      end else if (at_exp) begin
        if (ok_cur)       f_good = 1'b1;
        else if (slip_en) pend_n = 1'b1;
        else              f_bad  = 1'b1;
      end else if (pend) begin
        if (ok_cur) begin
          f_good = 1'b1;
          pos_n  = '0;
        end else begin
          f_bad = 1'b1;
        end
      end
      if (f_good) begin
        fs_n = 1'b1;
        if (state == ST_CHECK) begin
          good_n = good_inc[CNT_W-1:0];
          if (good_inc >= {1'b0, need_good}) begin
            st_n   = ST_LOCK;
            miss_n = '0;
          end
        end else begin
          miss_n = '0;
        end
      end
      if (f_bad) begin
        if (state == ST_CHECK) begin
          st_n  = ST_SEARCH;
          pos_n = '0;
        end else begin
          miss_n = miss_inc[CNT_W-1:0];
          if (miss_inc >= {1'b0, need_bad}) begin
            st_n  = ST_SEARCH;
            pos_n = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEARCH;
      pos   <= '0;
      fs    <= 1'b0;
      inv   <= 1'b0;
      good  <= '0;
      miss  <= '0;
      pend  <= 1'b0;
      dout  <= 1'b0;
    end else if (bit_en) begin
      state <= st_n;
      pos   <= pos_n;
      fs    <= fs_n;
      inv   <= inv_n;
      good  <= good_n;
      miss  <= miss_n;
      pend  <= pend_n;
      dout  <= din ^ inv_n;
    end
  end
endmodule

// File: rtl/tlm_frame_sync.sv
module tlm_frame_sync #(
  parameter int PAT_W   = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int DEF_LEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bit_en,
  input  logic              rec_bit,
  input  logic              ext_bit,
  output logic [1:0]        sync_state,
  output logic              frame_start,
  output logic [LEN_W-1:0]  frame_pos,
  output logic              data_out
);
  import fsync_pkg::*;

  localparam int LIM_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] pat, mask;
  logic [LEN_W-1:0] len;
  logic [LIM_W-1:0] lim_search, lim_check, lim_lock, err_true, err_inv;
  logic [CNT_W-1:0] need_good, need_bad;
  logic             auto_pol, slip_en, sel_bit;
  logic [1:0]       src_sel;
  fsync_state_e     state;

  fsync_regs #(.PAT_W(PAT_W), .LEN_W(LEN_W), .LIM_W(LIM_W), .CNT_W(CNT_W),
               .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEF_LEN(DEF_LEN)) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pat(pat), .mask(mask), .len(len), .lim_search(lim_search),
    .lim_check(lim_check), .lim_lock(lim_lock), .need_good(need_good),
    .need_bad(need_bad), .auto_pol(auto_pol), .slip_en(slip_en), .src_sel(src_sel));

  fsync_source #(.PAT_W(PAT_W), .LEN_W(LEN_W)) i_source (
    .clk(clk), .rst(rst), .bit_en(bit_en), .src_sel(src_sel), .rec_bit(rec_bit),
    .ext_bit(ext_bit), .pat(pat), .len(len), .bit_o(sel_bit));

  fsync_corr #(.PAT_W(PAT_W), .LIM_W(LIM_W)) i_corr (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(sel_bit), .pat(pat), .mask(mask),
    .err_true(err_true), .err_inv(err_inv));

  fsync_ctrl #(.LEN_W(LEN_W), .LIM_W(LIM_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .din(sel_bit), .err_true(err_true),
    .err_inv(err_inv), .len(len), .lim_search(lim_search), .lim_check(lim_check),
    .lim_lock(lim_lock), .need_good(need_good), .need_bad(need_bad),
    .auto_pol(auto_pol), .slip_en(slip_en), .state(state), .fs(frame_start),
    .pos(frame_pos), .dout(data_out));

  assign sync_state = state;
endmodule

// File: rtl/fsync_chk.sv
module fsync_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic [1:0]       sync_state,
  input logic             frame_start,
  input logic [LEN_W-1:0] frame_pos,
  input logic             data_out
);
  a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
    sync_state != 2'd3);

  a_r7_no_strobe_in_search: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> sync_state != 2'd0);

  a_r6_pos_zero_in_search: assert property (@(posedge clk) disable iff (rst)
    sync_state == 2'd0 |-> frame_pos == '0);

  a_r6_strobe_at_pos_zero: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> frame_pos == '0);

  a_r3_search_exit: assert property (@(posedge clk) disable iff (rst)
    (sync_state != 2'd0 && $past(sync_state) == 2'd0)
      |-> (sync_state == 2'd1 && frame_start));

  a_r4_lock_via_check: assert property (@(posedge clk) disable iff (rst)
    (sync_state == 2'd2 && $past(sync_state) != 2'd2) |-> $past(sync_state) == 2'd1);

  a_r12_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(sync_state) && $stable(frame_start) &&
                 $stable(frame_pos) && $stable(data_out)));
endmodule

bind tlm_frame_sync fsync_chk #(.LEN_W(LEN_W)) i_fsync_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .sync_state(sync_state),
  .frame_start(frame_start), .frame_pos(frame_pos), .data_out(data_out));

// File: tb/test_tlm_frame_sync.sv
module test_tlm_frame_sync;
  localparam int PW = 16;
  localparam int LW = 8;
  localparam int FL = 40;
  localparam logic [PW-1:0] PAT = 16'hEB90;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic bit_en = 1'b0, rec_bit = 1'b0, ext_bit = 1'b0;
  logic [1:0] sync_state;
  logic frame_start, data_out;
  logic [LW-1:0] frame_pos;

  int n_run = 0, n_fail = 0;
  int mode = 0;
  logic [1:0] e_st; logic e_fs, e_data; logic [LW-1:0] e_pos, f_pos, pen_pos;
  logic f_data; int mid_fs;

  tlm_frame_sync #(.PAT_W(PW), .LEN_W(LW), .CNT_W(8), .DATA_W(32), .ADDR_W(3),
                   .DEF_LEN(64)) i_tlm_frame_sync (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bit_en(bit_en), .rec_bit(rec_bit), .ext_bit(ext_bit), .sync_state(sync_state),
    .frame_start(frame_start), .frame_pos(frame_pos), .data_out(data_out));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0; cfg_we = 1'b0; rec_bit = 1'b0; ext_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // lims: search, check, lock; counts: good-to-lock, bad-to-search; ctrl word
  task automatic setup(input int ls, input int lc, input int ll, input int ng,
                       input int nb, input int ctrl, input int msk);
    do_reset();
    wr(0, int'(PAT)); wr(1, msk); wr(2, FL);
    wr(3, (ll << 16) | (lc << 8) | ls);
    wr(4, (nb << 8) | ng); wr(5, ctrl);
    mode = (ctrl >> 2) & 3;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rec_bit = (mode == 0) ? b : 1'b0;
    ext_bit = (mode == 1) ? b : 1'b0;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  function automatic logic fill(input int i);
    return (i % 4) == 0;
  endfunction

  // n-bit frame: filler then the sync word MSB first, err flips word bits, inv flips all
  task automatic send_frame(input int n, input logic [PW-1:0] err, input logic inv);
    mid_fs = 0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = (i < n - PW) ? fill(i) : (PAT[n-1-i] ^ err[n-1-i]);
      send_bit(b ^ inv);
      if (i == 0) begin f_pos = frame_pos; f_data = data_out; end
      if (i == n - 2) pen_pos = frame_pos;
      if (i < n - 1 && frame_start) mid_fs++;
    end
    e_st = sync_state; e_fs = frame_start; e_pos = frame_pos; e_data = data_out;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 state", sync_state, 0); chk("R1 strobe", frame_start, 0);
    chk("R1 pos", frame_pos, 0);    chk("R1 data", data_out, 0);
  endtask

  task automatic t_acquire();
    setup(0, 0, 0, 2, 2, 0, 16'hFFFF);
    send_frame(FL, 0, 0);
    chk("R3 to check", e_st, 1); chk("R3 strobe", e_fs, 1); chk("R3 pos", e_pos, 0);
    send_frame(FL, 0, 0);
    chk("R6 pos after sync", f_pos, 1); chk("R9 data", f_data, 1);
    chk("R7 single strobe", mid_fs, 0); chk("R6 wrap pos", pen_pos, FL - 1);
    chk("R4 still check", e_st, 1); chk("R7 strobe", e_fs, 1);
    send_frame(FL, 0, 0);
    chk("R4 lock", e_st, 2);
  endtask

  task automatic t_lock_tol();
    setup(0, 0, 2, 1, 2, 0, 16'hFFFF);
    send_frame(FL, 0, 0); send_frame(FL, 0, 0);
    chk("R5 locked", e_st, 2);
    send_frame(FL, 16'h0003, 0);
    chk("R5 two errors ok", e_fs, 1); chk("R2 two errors state", e_st, 2);
    send_frame(FL, 16'h0007, 0);
    chk("R5 bad no strobe", e_fs, 0); chk("R5 bad keeps lock", e_st, 2);
    chk("R5 counter runs", e_pos, 0);
    send_frame(FL, 0, 0);
    chk("R5 good resets miss", e_st, 2);
    send_frame(FL, 16'h0070, 0);
    chk("R5 one miss", e_st, 2);
    send_frame(FL, 16'h0700, 0);
    chk("R5 back to search", e_st, 0);
  endtask

  task automatic t_search_mask();
    setup(0, 0, 0, 2, 2, 0, 16'hFFFF);
    send_frame(FL, 16'h0001, 0);
    chk("R3 one error rejected", e_st, 0); chk("R3 no strobe", e_fs, 0);
    wr(1, 16'hFFF0);
    send_frame(FL, 16'h0001, 0);
    chk("R2 masked error ignored", e_st, 1);
    setup(1, 0, 0, 2, 2, 0, 16'hFFFF);
    send_frame(FL, 16'h0100, 0);
    chk("R3 search limit one", e_st, 1);
  endtask

  task automatic t_check_lim();
    setup(0, 1, 0, 3, 2, 0, 16'hFFFF);
    send_frame(FL, 0, 0);
    send_frame(FL, 16'h0010, 0);
    chk("R4 check tolerance", e_st, 1); chk("R4 check strobe", e_fs, 1);
    send_frame(FL, 16'h0011, 0);
    chk("R4 bad check to search", e_st, 0); chk("R4 bad no strobe", e_fs, 0);
  endtask

  task automatic t_polarity();
    setup(0, 0, 0, 2, 2, 0, 16'hFFFF);
    send_frame(FL, 0, 1);
    chk("R8 inverted rejected when off", e_st, 0);
    wr(5, 1);
    send_frame(FL, 0, 1);
    chk("R8 inverted accepted", e_st, 1); chk("R8 strobe", e_fs, 1);
    chk("R8 last bit corrected", e_data, 0);
    send_frame(FL, 0, 1);
    chk("R8 data inverted", f_data, 1); chk("R8 inverted check frame", e_fs, 1);
  endtask

  task automatic t_slip();
    setup(0, 0, 0, 1, 3, 2, 16'hFFFF);
    send_frame(FL, 0, 0); send_frame(FL, 0, 0);
    chk("R10 locked", e_st, 2);
    send_frame(FL - 1, 0, 0);
    chk("R10 early strobe", e_fs, 1); chk("R10 early pos", e_pos, 0);
    chk("R10 early state", e_st, 2);
    send_frame(FL, 0, 0);
    chk("R10 realigned", e_fs, 1);
    send_frame(FL + 1, 0, 0);
    chk("R10 late strobe", e_fs, 1); chk("R10 late pos", e_pos, 0);
    chk("R10 late no early strobe", mid_fs, 0);
    wr(5, 0);
    send_frame(FL, 0, 0);
    send_frame(FL - 1, 0, 0);
    chk("R10 off no strobe", e_fs, 0); chk("R10 off pos", e_pos, FL - 1);
  endtask

  task automatic t_source();
    setup(0, 0, 0, 2, 2, 4, 16'hFFFF);
    send_frame(FL, 0, 0);
    chk("R11 external source", e_st, 1);
    setup(0, 0, 0, 2, 2, 8, 16'hFFFF);
    send_frame(FL, 0, 0);
    chk("R11 generator sync", e_fs, 1); chk("R11 generator state", e_st, 1);
    chk("R11 generator fill", mid_fs, 0);
    send_frame(FL, 0, 0); send_frame(FL, 0, 0);
    chk("R11 generator lock", e_st, 2); chk("R11 generator fill data", f_data, 0);
  endtask

  task automatic t_hold();
    logic [1:0] s0; logic [LW-1:0] p0; logic d0, f0;
    setup(0, 0, 0, 1, 2, 0, 16'hFFFF);
    send_frame(FL, 0, 0);
    s0 = sync_state; p0 = frame_pos; d0 = data_out; f0 = frame_start;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rec_bit = ~rec_bit;
    end
    chk("R12 state held", sync_state, s0); chk("R12 pos held", frame_pos, p0);
    chk("R12 data held", data_out, d0);   chk("R12 strobe held", frame_start, f0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_lock_tol();
    t_search_mask();
    t_check_lim();
    t_polarity();
    t_slip();
    t_source();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule